// File: doc/BRIEF.md
# Load-Level Frequency and Voltage Scaling Register Controller

This block is a small bank of memory-mapped power-management registers. Software stores four CPU operating-point settings in it. Each setting holds a clock divider, a clock-source select, a PLL index and a voltage-set index. Software also picks which of the four settings is live. The block turns the live setting into registered selection outputs for the clock tree and the voltage regulator. Level 0 is the fastest operating point and level 3 is the slowest.

A simple 32-bit register port gives access to the bank. It has a write strobe, a read strobe, an address, write data and combinational read data. Two registers each hold two levels, one level in each 16-bit half. A third register holds one enable bit per steered output, plus a master scaling enable. A fourth register selects the active level.

While the master enable is set, the level settings and the active-level register are frozen. A saved state is therefore restored in three steps: clear the master enable, rewrite the other registers, and write the enable register last.

Top module: `dvfs_level_regs`

## Requirements
- R1: After reset, every register reads 0. The outputs show level 0, a divider of 1, a clock source of 0, a PLL index of 0 and a voltage set of 0. The enable outputs and the level-changed output are 0.
- R2: Each register can be written and reads back the full 32-bit word last stored: pair A at 0x18, pair B at 0x1C, dynamic control at 0x24 and load select at 0x30. The read data is combinational while the read strobe is high. It is 0 for any other address and whenever the read strobe is low.
- R3: Level 0 lives in bits 31:16 of 0x18 and level 1 in bits 15:0 of 0x18. Level 2 lives in bits 31:16 of 0x1C and level 3 in bits 15:0 of 0x1C.
- R4: Inside a 16-bit level field, bits 15:13 are the divider, bit 11 is the clock source (1 selects the PLL), bits 10:9 are the PLL index and bits 7:6 are the voltage-set index. All other bits of the field have no effect on the outputs.
- R5: In the dynamic control register, bit 31 is the master scaling enable. Bit 26 enables the clock-source output, bit 28 the PLL index, bit 29 the divider and bit 30 the voltage set. Each feature-enable output is high only when its bit and bit 31 are both set.
- R6: While the stored bit 31 is 1, writes to 0x18, 0x1C and 0x30 are ignored. Writes to 0x24 are always accepted.
- R7: While the master enable is 0, the outputs show the reset defaults from R1, whatever the other registers hold.
- R8: While the master enable is 1, each output field comes from the active level only when its own enable bit is set. Otherwise that field keeps its default. A stored divider of 0 is output as 1.
- R9: A register write shows on the outputs at the clock edge after the edge that stored it. When the active level changes, the level-changed output is high for exactly that one cycle.
- R10: While the master enable is 1, the active level is bits 1:0 of the load-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| clk_pll_o | output | 1 | Clock source select for the active level (1 = PLL) |
| pll_idx_o | output | 2 | PLL index for the active level |
| div_o | output | 3 | Effective divider for the active level (never 0) |
| vset_o | output | 2 | Voltage-set index for the active level |
| level_o | output | 2 | Active level |
| level_chg_o | output | 1 | One-cycle pulse when the active level changes |
| scale_on_o | output | 1 | Master scaling enable is on |
| en_clksel_o | output | 1 | Clock-source steering is active |
| en_pll_o | output | 1 | PLL-index steering is active |
| en_div_o | output | 1 | Divider steering is active |
| en_vdd_o | output | 1 | Voltage steering is active |

## Verification
Each of the four levels is given a different divider, PLL index, voltage set and clock source. Because of this, every level selection shows which half of which register was decoded. Spare bits are set inside one field, which shows that no neighbouring bit leaks into an output.

The enable register is tried fully set, with only the divider enabled, and cleared. These cases separate per-field gating from master gating. Writes made while scaling is on confirm that the configuration stays frozen. A level held across a re-enable confirms that the level-changed pulse fires only on a real change.

// File: rtl/dvfs_pkg.sv
`timescale 1ns/1ps
package dvfs_pkg;
  localparam int NLVL      = 4;
  localparam int LVL_W     = $clog2(NLVL);
  localparam int HALF_W    = 16;
  // positions inside a 16-bit level field
  localparam int F_DIV_LSB = 13;
  localparam int F_CLK_BIT = 11;
  localparam int F_PLL_LSB = 9;
  localparam int F_VS_LSB  = 6;
  // positions inside the dynamic control word
  localparam int DYN_CLKSEL = 26;
  localparam int DYN_PLL    = 28;
  localparam int DYN_DIV    = 29;
  localparam int DYN_VDD    = 30;
  localparam int DYN_MASTER = 31;

  typedef struct packed {
    logic [2:0] div;
    logic       clk_pll;
    logic [1:0] pll;
    logic [1:0] vset;
  } lvl_cfg_t;

  function automatic lvl_cfg_t unpack_half(input logic [HALF_W-1:0] h);
    lvl_cfg_t c;
    c.div     = h[F_DIV_LSB +: 3];
    c.clk_pll = h[F_CLK_BIT];
    c.pll     = h[F_PLL_LSB +: 2];
    c.vset    = h[F_VS_LSB +: 2];
    return c;
  endfunction

  function automatic logic [2:0] eff_div(input logic [2:0] d);
    return (d == 3'd0) ? 3'd1 : d;
  endfunction
endpackage

// File: rtl/dvfs_cfg_regs.sv
`timescale 1ns/1ps
module dvfs_cfg_regs
  import dvfs_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OFS_PAIR_A  = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_PAIR_B  = 8'h1C,
  parameter logic [ADDR_W-1:0] OFS_DYN     = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_LOAD    = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       pair_a_o,
  output logic [31:0]       pair_b_o,
  output logic [31:0]       dyn_o,
  output logic [31:0]       load_o
);
  localparam int NREG    = 4;
  localparam int IDX_DYN = 2;
  localparam logic [ADDR_W-1:0] OFS_TAB [NREG] = '{OFS_PAIR_A, OFS_PAIR_B, OFS_DYN, OFS_LOAD};

  logic [31:0]     reg_q [NREG];
  logic [NREG-1:0] hit;
  logic [NREG-1:0] wr_ok;
  logic            cfg_locked;   // scaling on: config frozen
  logic            wr_dropped;   // a write was refused

  assign cfg_locked = reg_q[IDX_DYN][DYN_MASTER];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [31:0] q;
    assign hit[g]   = (bus_addr == OFS_TAB[g]);
    assign wr_ok[g] = bus_wr && hit[g] && ((g == IDX_DYN) || !cfg_locked);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (wr_ok[g]) q <= bus_wdata;
    end
    assign reg_q[g] = q;
  end

  assign wr_dropped = bus_wr && (|hit) && !(|wr_ok);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) bus_rdata = reg_q[i];
    end
  end

  assign pair_a_o = reg_q[0];
  assign pair_b_o = reg_q[1];
  assign dyn_o    = reg_q[IDX_DYN];
  assign load_o   = reg_q[3];

  // R6: frozen registers keep their value across a refused write
  a_r6_pair_a_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dropped && hit[0]) |=> $stable(pair_a_o));
  a_r6_load_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dropped && hit[3]) |=> $stable(load_o));
  // R6: the control word always accepts a write
  a_r6_dyn_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DYN) |=> (dyn_o == $past(bus_wdata)));
  // R2: an unlocked write to the load register is stored whole
  a_r2_load_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LOAD && !dyn_o[DYN_MASTER]) |=> (load_o == $past(bus_wdata)));
endmodule

// File: rtl/dvfs_level_sel.sv
`timescale 1ns/1ps
module dvfs_level_sel
  import dvfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      pair_a,
  input  logic [31:0]      pair_b,
  input  logic             master,
  input  logic             en_clksel,
  input  logic             en_pll,
  input  logic             en_div,
  input  logic             en_vdd,
  input  logic [LVL_W-1:0] load_sel,
  output logic             clk_pll_o,
  output logic [1:0]       pll_idx_o,
  output logic [2:0]       div_o,
  output logic [1:0]       vset_o,
  output logic [LVL_W-1:0] level_o,
  output logic             level_chg_o,
  output logic             scale_on_o,
  output logic             en_clksel_o,
  output logic             en_pll_o,
  output logic             en_div_o,
  output logic             en_vdd_o
);
  lvl_cfg_t cfg [NLVL];

  // even levels take the upper half, odd the lower; pairs by level/2
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int  PAIR  = g / 2;
    localparam bit  UPPER = (g % 2) == 0;
    logic [31:0] src;
    assign src    = (PAIR == 0) ? pair_a : pair_b;
    assign cfg[g] = unpack_half(UPPER ? src[31:16] : src[15:0]);
  end

  logic             spare_unused;
  assign spare_unused = ^{pair_a[12], pair_a[8], pair_a[5:0], pair_a[28], pair_a[24], pair_a[21:16],
                          pair_b[12], pair_b[8], pair_b[5:0], pair_b[28], pair_b[24], pair_b[21:16]};

  logic [LVL_W-1:0] nxt_lvl;
  lvl_cfg_t         sel;
  logic             nxt_clk;
  logic [1:0]       nxt_pll, nxt_vs;
  logic [2:0]       nxt_div;
  logic             lvl_moves;   // active level differs from the shown one

  always_comb begin
    nxt_lvl = master ? load_sel : '0;
    sel     = cfg[nxt_lvl];
    nxt_clk = (master && en_clksel) ? sel.clk_pll : 1'b0;
    nxt_pll = (master && en_pll)    ? sel.pll     : 2'd0;
    nxt_div = (master && en_div)    ? eff_div(sel.div) : 3'd1;
    nxt_vs  = (master && en_vdd)    ? sel.vset    : 2'd0;
  end

  assign lvl_moves = (nxt_lvl != level_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pll_o   <= 1'b0;
      pll_idx_o   <= '0;
      div_o       <= 3'd1;
      vset_o      <= '0;
      level_o     <= '0;
      level_chg_o <= 1'b0;
      scale_on_o  <= 1'b0;
      en_clksel_o <= 1'b0;
      en_pll_o    <= 1'b0;
      en_div_o    <= 1'b0;
      en_vdd_o    <= 1'b0;
    end else begin
      clk_pll_o   <= nxt_clk;
      pll_idx_o   <= nxt_pll;
      div_o       <= nxt_div;
      vset_o      <= nxt_vs;
      level_o     <= nxt_lvl;
      level_chg_o <= lvl_moves;
      scale_on_o  <= master;
      en_clksel_o <= master && en_clksel;
      en_pll_o    <= master && en_pll;
      en_div_o    <= master && en_div;
      en_vdd_o    <= master && en_vdd;
    end
  end

  // R8: the divider output is never zero
  a_r8_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    div_o != 3'd0);
  // R9: pulse only on a real level move, and every move pulses
  a_r9_pulse_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    level_chg_o |-> (level_o != $past(level_o)));
  a_r9_move_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> level_chg_o);
  // R7: scaling off shows defaults
  a_r7_idle_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    !scale_on_o |-> (level_o == '0 && div_o == 3'd1 && !clk_pll_o && pll_idx_o == 2'd0 && vset_o == 2'd0));
endmodule

// File: rtl/dvfs_level_regs.sv
`timescale 1ns/1ps
module dvfs_level_regs
  import dvfs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              clk_pll_o,
  output logic [1:0]        pll_idx_o,
  output logic [2:0]        div_o,
  output logic [1:0]        vset_o,
  output logic [1:0]        level_o,
  output logic              level_chg_o,
  output logic              scale_on_o,
  output logic              en_clksel_o,
  output logic              en_pll_o,
  output logic              en_div_o,
  output logic              en_vdd_o
);
  logic [31:0] pair_a, pair_b, dyn_w, load_w;

  dvfs_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pair_a_o  (pair_a),
    .pair_b_o  (pair_b),
    .dyn_o     (dyn_w),
    .load_o    (load_w)
  );

  logic ctl_unused;
  assign ctl_unused = ^{dyn_w[27], dyn_w[25:0], load_w[31:LVL_W]};

  dvfs_level_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .pair_a      (pair_a),
    .pair_b      (pair_b),
    .master      (dyn_w[DYN_MASTER]),
    .en_clksel   (dyn_w[DYN_CLKSEL]),
    .en_pll      (dyn_w[DYN_PLL]),
    .en_div      (dyn_w[DYN_DIV]),
    .en_vdd      (dyn_w[DYN_VDD]),
    .load_sel    (load_w[LVL_W-1:0]),
    .clk_pll_o   (clk_pll_o),
    .pll_idx_o   (pll_idx_o),
    .div_o       (div_o),
    .vset_o      (vset_o),
    .level_o     (level_o),
    .level_chg_o (level_chg_o),
    .scale_on_o  (scale_on_o),
    .en_clksel_o (en_clksel_o),
    .en_pll_o    (en_pll_o),
    .en_div_o    (en_div_o),
    .en_vdd_o    (en_vdd_o)
  );

  // R5: a feature enable output never stands without the master
  a_r5_enable_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clksel_o || en_pll_o || en_div_o || en_vdd_o) |-> scale_on_o);
endmodule

// File: tb/dvfs_level_regs_tb_top.sv
`timescale 1ns/1ps
module dvfs_level_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_pll_o, level_chg_o, scale_on_o;
  logic        en_clksel_o, en_pll_o, en_div_o, en_vdd_o;
  logic [1:0]  pll_idx_o, vset_o, level_o;
  logic [2:0]  div_o;

  always #2 clk = ~clk;   // 250 MHz

  dvfs_level_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_pll_o(clk_pll_o), .pll_idx_o(pll_idx_o), .div_o(div_o),
    .vset_o(vset_o), .level_o(level_o), .level_chg_o(level_chg_o),
    .scale_on_o(scale_on_o), .en_clksel_o(en_clksel_o), .en_pll_o(en_pll_o),
    .en_div_o(en_div_o), .en_vdd_o(en_vdd_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_pa, m_pb, m_dyn, m_ld;
  int e_lvl, e_div, e_pll, e_vs;
  bit e_clk, e_chg, e_on, e_ec, e_ep, e_ed, e_ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_dyn = 0; m_ld = 0;
      e_lvl = 0; e_div = 1; e_pll = 0; e_vs = 0;
      e_clk = 0; e_chg = 0; e_on = 0; e_ec = 0; e_ep = 0; e_ed = 0; e_ev = 0;
    end else begin
      bit on; int nl; logic [31:0] w; logic [15:0] h; int d;
      on = m_dyn[31];
      nl = on ? int'(m_ld[1:0]) : 0;
      w  = (nl < 2) ? m_pa : m_pb;
      h  = (nl % 2 == 0) ? w[31:16] : w[15:0];
      e_chg = (nl != e_lvl);
      e_lvl = nl;
      e_on  = on;
      e_ec  = on && m_dyn[26]; e_ep = on && m_dyn[28];
      e_ed  = on && m_dyn[29]; e_ev = on && m_dyn[30];
      e_clk = e_ec ? h[11] : 1'b0;
      e_pll = e_ep ? int'(h[10:9]) : 0;
      e_vs  = e_ev ? int'(h[7:6]) : 0;
      d     = int'(h[15:13]);
      e_div = e_ed ? ((d == 0) ? 1 : d) : 1;
      if (bus_wr) begin
        if (bus_addr == 8'h24) m_dyn = bus_wdata;
        else if (!m_dyn[31]) begin
          if (bus_addr == 8'h18) m_pa = bus_wdata;
          if (bus_addr == 8'h1C) m_pb = bus_wdata;
          if (bus_addr == 8'h30) m_ld = bus_wdata;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(level_o == e_lvl[1:0],    "R10 model level",   {30'd0, level_o}, e_lvl);
      chk(div_o == e_div[2:0],      "R8 model divider",  {29'd0, div_o}, e_div);
      chk(pll_idx_o == e_pll[1:0],  "R4 model pll",      {30'd0, pll_idx_o}, e_pll);
      chk(vset_o == e_vs[1:0],      "R4 model vset",     {30'd0, vset_o}, e_vs);
      chk(clk_pll_o == e_clk,       "R4 model clksrc",   {31'd0, clk_pll_o}, {31'd0, e_clk});
      chk(level_chg_o == e_chg,     "R9 model pulse",    {31'd0, level_chg_o}, {31'd0, e_chg});
      chk({scale_on_o, en_clksel_o, en_pll_o, en_div_o, en_vdd_o} == {e_on, e_ec, e_ep, e_ed, e_ev},
          "R5 model enables", {27'd0, scale_on_o, en_clksel_o, en_pll_o, en_div_o, en_vdd_o},
          {27'd0, e_on, e_ec, e_ep, e_ed, e_ev});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic out_chk(input int lv, input int dv, input int pl, input int vs, input bit ck, input string tag);
    chk(level_o == lv[1:0] && div_o == dv[2:0] && pll_idx_o == pl[1:0] && vset_o == vs[1:0] && clk_pll_o == ck,
        tag, {19'd0, clk_pll_o, 2'd0, level_o, 1'b0, div_o, 2'd0, pll_idx_o, 2'd0, vset_o},
        {19'd0, ck, 2'd0, lv[1:0], 1'b0, dv[2:0], 2'd0, pl[1:0], 2'd0, vs[1:0]});
  endtask

  localparam logic [31:0] PA  = 32'h2C00_4A40;  // L0: div1 pll2 clk1 vs0 | L1: div2 pll1 clk1 vs1
  localparam logic [31:0] PB  = 32'h8E80_12FF;  // L2: div4 pll3 clk1 vs2 | L3: div0 pll1 clk0 vs3 + spare bits
  localparam logic [31:0] ALL = 32'hF400_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd_chk(8'h18, 0, "R1 pair A reset"); rd_chk(8'h1C, 0, "R1 pair B reset");
    rd_chk(8'h24, 0, "R1 dyn reset");    rd_chk(8'h30, 0, "R1 load reset");
    out_chk(0, 1, 0, 0, 0, "R1 output defaults");
    chk(!level_chg_o && !scale_on_o, "R1 flags low", {30'd0, level_chg_o, scale_on_o}, 0);
    // R2
    wr(8'h18, PA); wr(8'h1C, PB); wr(8'h30, 32'hFFFF_FFF2);
    rd_chk(8'h18, PA, "R2 pair A readback"); rd_chk(8'h1C, PB, "R2 pair B readback");
    rd_chk(8'h30, 32'hFFFF_FFF2, "R2 load readback");
    rd_chk(8'h20, 0, "R2 unmapped reads zero");
    @(negedge clk); bus_addr = 8'h18; #1 chk(bus_rdata == 0, "R2 no strobe reads zero", bus_rdata, 0);
    // R7: config present but master off
    out_chk(0, 1, 0, 0, 0, "R7 defaults while off");
    // R3 R4 R10 R9: enable all, level 2
    wr(8'h24, ALL);
    @(negedge clk);
    out_chk(2, 4, 3, 2, 1, "R3 R4 R10 level 2 fields");
    chk(level_chg_o, "R9 pulse on move", {31'd0, level_chg_o}, 1);
    chk(en_clksel_o && en_pll_o && en_div_o && en_vdd_o && scale_on_o, "R5 enables on",
        {27'd0, scale_on_o, en_clksel_o, en_pll_o, en_div_o, en_vdd_o}, 32'h1F);
    @(negedge clk);
    chk(!level_chg_o, "R9 pulse single cycle", {31'd0, level_chg_o}, 0);
    // R6 lock
    wr(8'h30, 32'h3); wr(8'h18, 32'h0);
    rd_chk(8'h30, 32'hFFFF_FFF2, "R6 load frozen"); rd_chk(8'h18, PA, "R6 pair A frozen");
    @(negedge clk);
    out_chk(2, 4, 3, 2, 1, "R6 level unchanged under lock");
    // R8 partial enables: divider only
    wr(8'h24, 32'hA000_0000);
    @(negedge clk);
    out_chk(2, 4, 0, 0, 0, "R8 divider only");
    // R7 master off
    wr(8'h24, 32'h7400_0000);
    @(negedge clk);
    out_chk(0, 1, 0, 0, 0, "R7 feature bits without master");
    chk(level_chg_o && !en_div_o, "R9 R5 pulse back to 0", {30'd0, level_chg_o, en_div_o}, 32'h2);
    // restore order: unlocked writes, control last -> level 3
    wr(8'h30, 32'h3); wr(8'h24, ALL);
    @(negedge clk);
    out_chk(3, 1, 1, 3, 0, "R3 R8 level 3, zero divider as 1");
    // level 1
    wr(8'h24, 0); wr(8'h30, 32'h1); wr(8'h24, ALL);
    @(negedge clk);
    out_chk(1, 2, 1, 1, 1, "R3 R10 level 1 fields");
    // level 0 held across re-enable: no pulse
    wr(8'h24, 0); wr(8'h30, 32'h0); wr(8'h24, ALL);
    @(negedge clk);
    out_chk(0, 1, 2, 0, 1, "R3 level 0 fields");
    chk(!level_chg_o, "R9 no pulse when level held", {31'd0, level_chg_o}, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule